// File: doc/BRIEF.md
# Input Sample Rate Measurement Unit

This block measures the sample rate of an incoming serial digital audio stream. It counts cycles of a fixed reference crystal clock between consecutive rising edges of a frame-rate strobe recovered from the stream. The recovered clock plays no part in the count. The count is 8 bits wide. The unit compares it against tolerance windows around the common audio rates and produces a 4-bit rate class. The count and the class are offered together as one 12-bit word on a read port.

There are two operating modes. With `contMode` low (auto-stop), the unit measures only while the receive lock-error flag `lockErr` is high. When lock is reached, the flag falls and the reference oscillator is gated. The last completed window then stays frozen until lock is lost again. With `contMode` high, every frame window refreshes the result, so the reading follows rate changes within the capture range.

Both inputs are assumed to be already synchronous to the reference clock `clk`. The default reference is 6.144 MHz. At that frequency an 8-bit count covers rates above 24 kHz.

Top module: `rate_meter`

## Requirements
- R1: After reset, `rdData` reads 12'hF00 (class 0xF, count 0) and `measValid` is 0.
- R2: A completed window yields a count equal to the number of `clk` rising edges from one sampled rising edge of `frameStrobe` to the next. The result appears on `rdData` one cycle after the closing edge, provided `rdHold` is low.
- R3: A window longer than 255 cycles reports a count of 255. The counter never wraps.
- R4: The class is computed from the count using windows of ±3% around REF_HZ/rate. Class 1 is 32 kHz, 2 is 44.1 kHz, 3 is 48 kHz, 4 is 88.2 kHz, 5 is 96 kHz, 6 is 176.4 kHz and 7 is 192 kHz. Any count outside every window gives class 0xF.
- R5: `rdData[11:8]` carries the class and `rdData[7:0]` carries the count. Both always come from the same window.
- R6: With `contMode` high, every completed window replaces the result, whatever the level of `lockErr`.
- R7: With `contMode` low, only windows that lie wholly within a period of `lockErr` high are captured. While `lockErr` is low, the result does not change.
- R8: `measValid` rises with the first captured window. It is cleared on the cycle after `lockErr` rises. After that rise, the first strobe edge only opens a new window and does not set `measValid`.
- R9: While `rdHold` is high, `rdData` does not change. A result captured during the hold appears one cycle after `rdHold` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference crystal clock, the measurement time base |
| rst_n | input | 1 | Active-low synchronous reset |
| frameStrobe | input | 1 | Recovered frame-rate strobe; each rising edge bounds a window |
| lockErr | input | 1 | Receive lock-error flag; high while the PLL is unlocked |
| contMode | input | 1 | 1 = continuous tracking, 0 = auto-stop on lock |
| rdHold | input | 1 | High while the host reads; freezes the read snapshot |
| rdData | output | 12 | Snapshot {class[3:0], count[7:0]} |
| measValid | output | 1 | A window has been captured since the last loss of lock |

## Verification
The bench sweeps the window length across every value from 2 to 300 cycles. Each edge of every class window is therefore hit: a design with an off-by-one ceiling or floor in a bound misclassifies exactly the boundary counts. A counter that wraps instead of saturating shows small counts for long windows. A counter that starts at zero instead of one reports every count one short. In auto-stop mode, the bench feeds windows while locked to catch a design that keeps updating after lock. It also re-raises the lock error to catch a design that keeps a stale valid flag or captures a partial window from the first edge. A long host read overlapping a new capture catches a snapshot that tears mid-read.

// File: rtl/rate_meter_pkg.sv
package rate_meter_pkg;

  localparam int NUM_RATES = 7;

  typedef struct packed {
    logic run;      // reference clock gated on
    logic restart;  // strobe edge: begin a new window
    logic capture;  // strobe edge closing an armed window
  } meas_ctl_t;

  function automatic longint rate_hz(input int idx);
    case (idx)
      0: return 64'd32000;
      1: return 64'd44100;
      2: return 64'd48000;
      3: return 64'd88200;
      4: return 64'd96000;
      5: return 64'd176400;
      default: return 64'd192000;
    endcase
  endfunction

  // lowest count accepted for a rate (rounded up)
  function automatic longint win_lo(input longint refHz, input int idx, input int tolPct);
    longint den;
    den = rate_hz(idx) * 100;
    return (refHz * longint'(100 - tolPct) + den - 1) / den;
  endfunction

  // highest count accepted for a rate (rounded down)
  function automatic longint win_hi(input longint refHz, input int idx, input int tolPct);
    longint den;
    den = rate_hz(idx) * 100;
    return (refHz * longint'(100 + tolPct)) / den;
  endfunction

endpackage

// File: rtl/rate_meter_ctrl.sv
module rate_meter_ctrl
  import rate_meter_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      frameStrobe,
  input  logic      lockErr,
  input  logic      contMode,
  output meas_ctl_t ctl,
  output logic      valid
);

  logic prevStrobe;
  logic prevErr;
  logic armed;
  logic validReg;

  logic measEn;
  logic strobeEdge;
  logic lossOfLock;

  assign measEn     = contMode | lockErr;
  assign strobeEdge = frameStrobe & ~prevStrobe;
  assign lossOfLock = lockErr & ~prevErr;

  always_comb begin
    ctl.run     = measEn;
    ctl.restart = strobeEdge & measEn;
    ctl.capture = strobeEdge & measEn & armed & ~lossOfLock;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prevStrobe <= 1'b0;
      prevErr    <= 1'b0;
      armed      <= 1'b0;
      validReg   <= 1'b0;
    end else begin
      prevStrobe <= frameStrobe;
      prevErr    <= lockErr;
      if (!measEn)         armed <= 1'b0;
      else if (strobeEdge) armed <= 1'b1;
      else if (lossOfLock) armed <= 1'b0;
      if (lossOfLock)       validReg <= 1'b0;
      else if (ctl.capture) validReg <= 1'b1;
    end
  end

  assign valid = validReg;

  // R8: a fresh loss of lock always drops the valid flag
  p_valid_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (lockErr && !prevErr) |=> !valid);

  // R7: locked in auto-stop mode means nothing is captured
  p_locked_no_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!contMode && !lockErr) |-> !ctl.capture);

  // R8: the first edge after arming is cleared never captures
  p_first_edge_opens_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !measEn |=> !ctl.capture);

endmodule

// File: rtl/rate_meter_dp.sv
module rate_meter_dp
  import rate_meter_pkg::*;
#(
  parameter int     CNT_W   = 8,
  parameter int     CODE_W  = 4,
  parameter longint REF_HZ  = 6144000,
  parameter int     TOL_PCT = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  meas_ctl_t                ctl,
  input  logic                     rdHold,
  output logic [CODE_W+CNT_W-1:0]  rdData
);

  localparam int RD_W = CODE_W + CNT_W;
  localparam logic [CNT_W-1:0]  CNT_MAX   = '1;
  localparam logic [CODE_W-1:0] CODE_NONE = '1;

  logic [CNT_W-1:0]     cnt;
  logic [31:0]          cntWide;
  logic [NUM_RATES-1:0] hits;
  logic [CODE_W-1:0]    code;
  logic [RD_W-1:0]      resultReg;
  logic [RD_W-1:0]      snap;

  assign cntWide = 32'(cnt);

  // one tolerance comparator per standard rate
  for (genvar gi = 0; gi < NUM_RATES; gi++) begin : g_class
    localparam logic [31:0] LO = 32'(win_lo(REF_HZ, gi, TOL_PCT));
    localparam logic [31:0] HI = 32'(win_hi(REF_HZ, gi, TOL_PCT));
    assign hits[gi] = (cntWide >= LO) && (cntWide <= HI);
  end

  always_comb begin
    code = CODE_NONE;
    for (int i = NUM_RATES - 1; i >= 0; i--) begin
      if (hits[i]) code = CODE_W'(i + 1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= '0;
      resultReg <= {CODE_NONE, {CNT_W{1'b0}}};
      snap      <= {CODE_NONE, {CNT_W{1'b0}}};
    end else begin
      if (ctl.run) begin
        if (ctl.restart)         cnt <= CNT_W'(1);
        else if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
      end
      if (ctl.capture) resultReg <= {code, cnt};
      if (!rdHold)     snap      <= resultReg;
    end
  end

  assign rdData = snap;

  // R3: a saturated counter stays saturated until the next window opens
  p_no_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.run && !ctl.restart && cnt == CNT_MAX) |=> cnt == CNT_MAX);

  // R7: the result only moves when the controller signals a capture
  p_result_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.capture |=> $stable(resultReg));

  // R9: the read snapshot never changes during a host read
  p_hold_snapshot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rdHold |=> $stable(rdData));

  // R2: gating the reference clock stops the counter
  p_gated_stop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.run |=> $stable(cnt));

endmodule

// File: rtl/rate_meter.sv
module rate_meter
  import rate_meter_pkg::*;
#(
  parameter int     CNT_W   = 8,
  parameter int     CODE_W  = 4,
  parameter longint REF_HZ  = 6144000,
  parameter int     TOL_PCT = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    frameStrobe,
  input  logic                    lockErr,
  input  logic                    contMode,
  input  logic                    rdHold,
  output logic [CODE_W+CNT_W-1:0] rdData,
  output logic                    measValid
);

  meas_ctl_t ctl;

  rate_meter_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .frameStrobe (frameStrobe),
    .lockErr     (lockErr),
    .contMode    (contMode),
    .ctl         (ctl),
    .valid       (measValid)
  );

  rate_meter_dp #(
    .CNT_W   (CNT_W),
    .CODE_W  (CODE_W),
    .REF_HZ  (REF_HZ),
    .TOL_PCT (TOL_PCT)
  ) u_dp (
    .clk    (clk),
    .rst_n  (rst_n),
    .ctl    (ctl),
    .rdHold (rdHold),
    .rdData (rdData)
  );

endmodule

// File: tb/rate_meter_test.sv
`timescale 1ns/1ps
module rate_meter_test;

  localparam longint REF_HZ = 6144000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frameStrobe = 1'b0;
  logic        lockErr = 1'b0;
  logic        contMode = 1'b1;
  logic        rdHold = 1'b0;
  logic [11:0] rdData;
  logic        measValid;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rate_meter uut (
    .clk(clk), .rst_n(rst_n), .frameStrobe(frameStrobe), .lockErr(lockErr),
    .contMode(contMode), .rdHold(rdHold), .rdData(rdData), .measValid(measValid)
  );

  function automatic logic [11:0] expect_word(input int period);
    longint rates[7] = '{32000, 44100, 48000, 88200, 96000, 176400, 192000};
    int c;
    logic [3:0] cls;
    c = (period > 255) ? 255 : period;
    cls = 4'hF;
    for (int i = 0; i < 7; i++) begin
      if (longint'(c) * rates[i] * 100 >= REF_HZ * 97 &&
          longint'(c) * rates[i] * 100 <= REF_HZ * 103) cls = 4'(i + 1);
    end
    return {cls, 8'(c)};
  endfunction

  task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // two strobe edges exactly 'period' cycles apart; returns 1.5 cycles after the closing edge
  task automatic window(input int period);
    frameStrobe = 1'b1;
    @(negedge clk) frameStrobe = 1'b0;
    repeat (period - 1) @(negedge clk);
    frameStrobe = 1'b1;
    @(negedge clk) frameStrobe = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset word", rdData, 12'hF00);
    check("R1 reset valid", {11'b0, measValid}, 12'h000);

    // R2 R3 R4 R5 R6: sweep every window length in continuous mode
    for (int p = 2; p <= 300; p++) begin
      window(p);
      check(p > 255 ? "R3 saturation" : "R4 class / R2 count", rdData, expect_word(p));
    end
    check("R6 valid in continuous mode", {11'b0, measValid}, 12'h001);

    // R9: snapshot frozen during a read
    window(100);
    check("R5 word layout", rdData, {4'hF, 8'd100});
    rdHold = 1'b1;
    window(128);
    check("R9 held during read", rdData, {4'hF, 8'd100});
    rdHold = 1'b0;
    @(negedge clk);
    check("R9 released after read", rdData, {4'h3, 8'd128});

    // R7 R8: auto-stop mode
    contMode = 1'b0;
    @(negedge clk);
    lockErr = 1'b1;
    @(negedge clk);
    check("R8 valid cleared on loss of lock", {11'b0, measValid}, 12'h000);
    window(140);
    check("R7 captured while unlocked", rdData, {4'h2, 8'd140});
    check("R8 valid after first window", {11'b0, measValid}, 12'h001);
    lockErr = 1'b0;
    window(128);
    window(64);
    check("R7 frozen while locked", rdData, {4'h2, 8'd140});
    check("R7 valid kept while locked", {11'b0, measValid}, 12'h001);
    lockErr = 1'b1;
    @(negedge clk);
    check("R8 valid cleared again", {11'b0, measValid}, 12'h000);
    frameStrobe = 1'b1;
    @(negedge clk) frameStrobe = 1'b0;
    repeat (3) @(negedge clk);
    check("R8 first edge only opens", {11'b0, measValid}, 12'h000);
    check("R8 first edge no capture", rdData, {4'h2, 8'd140});
    window(64);
    check("R7 new measurement", rdData, {4'h5, 8'd64});
    check("R8 valid after new window", {11'b0, measValid}, 12'h001);

    // R6: continuous mode updates even with lock reached
    contMode = 1'b1;
    lockErr = 1'b0;
    window(32);
    check("R6 continuous while locked", rdData, {4'h7, 8'd32});

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule